// File: doc/BRIEF.md
# Chien Root Search with Failure Check

This block takes the error locator and error evaluator polynomials that a key-equation solver produces for one block of a Reed-Solomon code over GF(2^8). The default code is shortened to 40 symbols with up to 4 correctable errors. A one-cycle start pulse loads the coefficients and the declared locator degree. The block then tests one symbol position per clock, in the order the symbols were received. At each position it evaluates both polynomials and raises a location strobe wherever the locator vanishes. For a following magnitude unit, it passes on the evaluator value and an inverter request.

The unit counts the roots it finds. When the count reaches the declared degree, it freezes its coefficient registers and stops, so the comparison that decides success is also the shut-off condition. If the count is still short when the last parity position has been tested, the block reports a decode failure. Roots found at parity positions count toward the failure check, but they raise no inverter request and pass on no evaluator value, because parity symbols are never corrected.

Top module: `chien_search`

## Requirements
- R1: The cycle after `start_i` with a nonzero degree, `pos_valid_o` is high with `pos_o` = 0. Position j corresponds to received symbol j, which has codeword power N-1-j. While the search runs, `pos_o` advances by one each clock.
- R2: At a valid position j, `err_loc_o` is high exactly when the locator, evaluated at alpha^-(N-1-j), is zero. Here alpha = 0x02 in the field with polynomial 0x11D, and locator coefficient i sits at bits [8i+7:8i] of `loc_coef_i`.
- R3: `mag_eval_o` equals the evaluator value at the same point in a cycle where `inv_req_o` is high, and is zero in every other cycle. Evaluator coefficient i sits at bits [8i+7:8i] of `mag_coef_i`.
- R4: `inv_req_o` is high only at located positions with j < N-2T. A root at a parity position raises `err_loc_o` and counts, but raises no request.
- R5: At the position where the root count reaches the declared degree, the search stops. From the next cycle, `pos_valid_o` is low, `done_o` is high and `fail_o` is low.
- R6: If position N-1 is passed with fewer roots than the declared degree, then `done_o` and `fail_o` are high from the next cycle, with `pos_o` held at N-1.
- R7: A start with degree 0 tests no position. The next cycle shows `done_o` high, `fail_o` low and `root_cnt_o` = 0.
- R8: `root_cnt_o` equals the number of strobed positions since the last start. After `done_o` rises, it holds its value, together with `fail_o` and `done_o`, until the next start.
- R9: During reset and after it, until the first start, all outputs are zero.
- R10: A start that arrives during a search restarts it at position 0 with a zero count and the new polynomials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the polynomials and begin the search |
| loc_deg_i | input | 3 | Declared locator degree |
| loc_coef_i | input | 40 | Locator coefficients 0..4, 8 bits each |
| mag_coef_i | input | 32 | Evaluator coefficients 0..3, 8 bits each |
| pos_valid_o | output | 1 | A position is being tested this cycle |
| pos_o | output | 6 | Index of the tested position in received order |
| err_loc_o | output | 1 | The locator vanishes at this position |
| inv_req_o | output | 1 | Correction request for a located data position |
| mag_eval_o | output | 8 | Evaluator value for the magnitude unit, or zero |
| done_o | output | 1 | The search has ended |
| fail_o | output | 1 | The root count missed the declared degree |
| root_cnt_o | output | 3 | Number of roots found |

## Verification
Two functions can fall in the same clock: reporting a location, and ending the search. This happens when the last expected root also sits at a boundary position: position 0, the last data position, a parity position, or position N-1, where the end-of-block failure test is also pending. The bench provokes every case. It sweeps a single root over all 40 positions and adjacent root pairs over every neighbouring pair, and it places roots at the data/parity seam and at the final symbol. For each case it recomputes the locator and evaluator values at every position by direct field arithmetic. It then requires the strobe, the request and the evaluator value in that cycle, followed by a clean stop with no failure in the next cycle. Locators whose roots lie partly outside the shortened block, or whose coefficients are arbitrary, drive the search to the end of the block, where the failure flag is judged.

// File: rtl/chien_pkg.sv
`timescale 1ns/1ps
package chien_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;

  // elaboration-time field product, fields up to 16 bits
  function automatic logic [15:0] gf_mul_c(input logic [15:0] a, input logic [15:0] b,
                                           input int m, input logic [16:0] poly);
    logic [15:0] acc;
    logic [16:0] sh;
    acc = '0;
    sh  = {1'b0, a};
    for (int i = 0; i < 16; i++) begin
      if (i < m) begin
        if (b[i]) acc ^= sh[15:0];
        sh = {sh[15:0], 1'b0};
        if (sh[m]) sh ^= poly;
      end
    end
    return acc;
  endfunction

  function automatic logic [15:0] gf_alpha_pow(input int e, input int m, input logic [16:0] poly);
    logic [15:0] r;
    r = 16'd1;
    for (int i = 0; i < e; i++) r = gf_mul_c(r, 16'd2, m, poly);
    return r;
  endfunction

endpackage

// File: rtl/chien_bank.sv
`timescale 1ns/1ps
module chien_bank import chien_pkg::*; #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11D,
  parameter int         N    = 40,
  parameter int         NT   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [NT*M-1:0] coef_i,
  output logic [M-1:0]  sum_o
);
  localparam int NFULL = (1 << M) - 1;
  localparam int SHIFT = NFULL - N + 1;  // alpha^SHIFT = alpha^-(N-1): first received symbol

  function automatic logic [M-1:0] mul_m(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc ^= x;
      x = x[M-1] ? ({x[M-2:0], 1'b0} ^ POLY[M-1:0]) : {x[M-2:0], 1'b0};
    end
    return acc;
  endfunction

  logic [NT*M-1:0] terms_w;

  for (genvar gi = 0; gi < NT; gi++) begin : g_term
    localparam logic [15:0] SCALE = gf_alpha_pow((gi * SHIFT) % NFULL, M, 17'(POLY));
    localparam logic [15:0] STEP  = gf_alpha_pow(gi, M, 17'(POLY));
    logic [M-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     r_q <= '0;
      else if (load_i) r_q <= mul_m(coef_i[gi*M +: M], SCALE[M-1:0]);
      else if (step_i) r_q <= mul_m(r_q, STEP[M-1:0]);
    end

    assign terms_w[gi*M +: M] = r_q;
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NT; i++) sum_o ^= terms_w[i*M +: M];
  end

endmodule

// File: rtl/chien_ctrl.sv
`timescale 1ns/1ps
module chien_ctrl import chien_pkg::*; #(
  parameter int N  = 40,
  parameter int DW = 3,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] deg_i,
  input  logic          root_i,
  output logic          active_o,
  output logic          step_o,
  output logic [PW-1:0] pos_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] cnt_o
);
  scan_state_e   st_q;
  logic [DW-1:0] deg_q, cnt_q, cnt_nx;
  logic [PW-1:0] pos_q;
  logic          fail_q, all_found, at_end;

  assign cnt_nx    = cnt_q + DW'(root_i);
  assign all_found = (cnt_nx == deg_q);   // failure comparator doubles as shut-off
  assign at_end    = (pos_q == PW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      deg_q  <= '0;
      cnt_q  <= '0;
      pos_q  <= '0;
      fail_q <= 1'b0;
    end else if (start_i) begin
      deg_q  <= deg_i;
      cnt_q  <= '0;
      pos_q  <= '0;
      fail_q <= 1'b0;
      st_q   <= (deg_i == '0) ? ST_DONE : ST_SCAN;
    end else if (st_q == ST_SCAN) begin
      cnt_q <= cnt_nx;
      if (all_found) begin
        st_q <= ST_DONE;
      end else if (at_end) begin
        st_q   <= ST_DONE;
        fail_q <= 1'b1;
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign active_o = (st_q == ST_SCAN);
  assign step_o   = active_o && !all_found && !at_end;
  assign done_o   = (st_q == ST_DONE);
  assign fail_o   = fail_q;
  assign pos_o    = pos_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/chien_search.sv
`timescale 1ns/1ps
module chien_search #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11D,
  parameter int         N    = 40,
  parameter int         T    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [$clog2(T+1)-1:0] loc_deg_i,
  input  logic [(T+1)*M-1:0]   loc_coef_i,
  input  logic [T*M-1:0]       mag_coef_i,
  output logic                 pos_valid_o,
  output logic [$clog2(N)-1:0] pos_o,
  output logic                 err_loc_o,
  output logic                 inv_req_o,
  output logic [M-1:0]         mag_eval_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [$clog2(T+1)-1:0] root_cnt_o
);
  localparam int K  = N - 2 * T;
  localparam int DW = $clog2(T + 1);
  localparam int PW = $clog2(N);

  logic [M-1:0] loc_sum, mag_sum;
  logic         active, step;

  chien_bank #(.M(M), .POLY(POLY), .N(N), .NT(T + 1)) u_loc_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .step_i (step),
    .coef_i (loc_coef_i),
    .sum_o  (loc_sum)
  );

  chien_bank #(.M(M), .POLY(POLY), .N(N), .NT(T)) u_mag_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .step_i (step),
    .coef_i (mag_coef_i),
    .sum_o  (mag_sum)
  );

  chien_ctrl #(.N(N), .DW(DW), .PW(PW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .deg_i    (loc_deg_i),
    .root_i   (err_loc_o),
    .active_o (active),
    .step_o   (step),
    .pos_o    (pos_o),
    .done_o   (done_o),
    .fail_o   (fail_o),
    .cnt_o    (root_cnt_o)
  );

  assign pos_valid_o = active;
  assign err_loc_o   = active && (loc_sum == '0);
  assign inv_req_o   = err_loc_o && (pos_o < PW'(K));  // parity symbols are never corrected
  assign mag_eval_o  = inv_req_o ? mag_sum : '0;

endmodule

// File: rtl/chien_search_chk.sv
`timescale 1ns/1ps
module chien_search_chk #(
  parameter int N  = 40,
  parameter int K  = 32,
  parameter int M  = 8,
  parameter int DW = 3,
  parameter int PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [DW-1:0] loc_deg_i,
  input logic          pos_valid_o,
  input logic [PW-1:0] pos_o,
  input logic          err_loc_o,
  input logic          inv_req_o,
  input logic [M-1:0]  mag_eval_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [DW-1:0] root_cnt_o
);
  assert_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_valid_o && !err_loc_o && !start_i && (pos_o != PW'(N - 1))
    |=> pos_valid_o && (pos_o == $past(pos_o) + PW'(1)));

  assert_strobe_in_scan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_loc_o |-> pos_valid_o);

  assert_mag_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_eval_o != '0) |-> inv_req_o);

  assert_parity_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |-> err_loc_o && (pos_o < PW'(K)));

  assert_fail_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && !pos_valid_o && (pos_o == PW'(N - 1)));

  assert_no_search_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (loc_deg_i == '0) |=> done_o && !fail_o && !pos_valid_o && (root_cnt_o == '0));

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !pos_valid_o && $stable(root_cnt_o) && $stable(fail_o));

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (loc_deg_i != '0) |=> pos_valid_o && (pos_o == '0) && !done_o && (root_cnt_o == '0));

endmodule

bind chien_search chien_search_chk #(
  .N(N), .K(K), .M(M), .DW(DW), .PW(PW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .loc_deg_i   (loc_deg_i),
  .pos_valid_o (pos_valid_o),
  .pos_o       (pos_o),
  .err_loc_o   (err_loc_o),
  .inv_req_o   (inv_req_o),
  .mag_eval_o  (mag_eval_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .root_cnt_o  (root_cnt_o)
);

// File: tb/chien_search_test.sv
`timescale 1ns/1ps
module chien_search_test;
  localparam int N = 40;
  localparam int K = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  loc_deg_i = '0;
  logic [39:0] loc_coef_i = '0;
  logic [31:0] mag_coef_i = '0;
  logic        pos_valid_o, err_loc_o, inv_req_o, done_o, fail_o;
  logic [5:0]  pos_o;
  logic [7:0]  mag_eval_o;
  logic [2:0]  root_cnt_o;

  always #2 clk_i = ~clk_i;

  chien_search uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .loc_deg_i(loc_deg_i),
    .loc_coef_i(loc_coef_i), .mag_coef_i(mag_coef_i), .pos_valid_o(pos_valid_o),
    .pos_o(pos_o), .err_loc_o(err_loc_o), .inv_req_o(inv_req_o), .mag_eval_o(mag_eval_o),
    .done_o(done_o), .fail_o(fail_o), .root_cnt_o(root_cnt_o)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  string cur_tag = "";
  int    lam[5];
  int    om[4];

  function automatic int gmul(input int a, input int b);
    int acc, x;
    acc = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) acc ^= x;
      x = x << 1;
      if (x & 'h100) x ^= 'h11D;
    end
    return acc;
  endfunction

  function automatic int apow(input int e);
    int r;
    r = 1;
    for (int i = 0; i < (e % 255); i++) r = gmul(r, 2);
    return r;
  endfunction

  function automatic int eval_lam(input int x);
    int acc;
    acc = 0;
    for (int i = 4; i >= 0; i--) acc = gmul(acc, x) ^ lam[i];
    return acc;
  endfunction

  function automatic int eval_om(input int x);
    int acc;
    acc = 0;
    for (int i = 3; i >= 0; i--) acc = gmul(acc, x) ^ om[i];
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, cur_tag, act, exp);
    end
  endtask

  // locator = product of (1 + alpha^p x) over the given powers
  task automatic build_loc(input int np, input int p0, input int p1, input int p2, input int p3);
    int pw[4];
    int a;
    pw = '{p0, p1, p2, p3};
    lam = '{1, 0, 0, 0, 0};
    for (int r = 0; r < np; r++) begin
      a = apow(pw[r]);
      for (int i = 4; i >= 1; i--) lam[i] = lam[i] ^ gmul(a, lam[i-1]);
    end
  endtask

  task automatic run_case(input string tag, input int deg, input int abort_after, input bit restart);
    int cnt, x, lv, ov, emag;
    bit stopped, eloc, einv;
    cur_tag = tag;
    for (int i = 0; i < 5; i++) loc_coef_i[i*8 +: 8] = 8'(lam[i]);
    for (int i = 0; i < 4; i++) mag_coef_i[i*8 +: 8] = 8'(om[i]);
    loc_deg_i = 3'(deg);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 0;
    stopped = 1'b0;
    if (deg == 0) begin
      chk(done_o && !fail_o && !pos_valid_o && root_cnt_o == 0, "R7",
          {done_o, fail_o, pos_valid_o}, 3'b100);
      return;
    end
    for (int j = 0; j < N; j++) begin
      x = apow(255 - (N - 1 - j));
      lv = eval_lam(x);
      ov = eval_om(x);
      eloc = (lv == 0);
      einv = eloc && (j < K);
      emag = einv ? ov : 0;
      chk(pos_valid_o && pos_o == 6'(j), (restart && j == 0) ? "R10" : "R1",
          pos_valid_o ? int'(pos_o) : -1, j);
      chk(err_loc_o == eloc, "R2", err_loc_o, eloc);
      chk(inv_req_o == einv, "R4", inv_req_o, einv);
      chk(mag_eval_o == 8'(emag), "R3", mag_eval_o, emag);
      if (eloc) cnt++;
      if (abort_after == j) return;
      if (cnt == deg) begin
        stopped = 1'b1;
        break;
      end
      @(negedge clk_i);
    end
    if (stopped) @(negedge clk_i);
    if (stopped)
      chk(done_o && !fail_o && !pos_valid_o, "R5", {done_o, fail_o, pos_valid_o}, 3'b100);
    else
      chk(done_o && fail_o && !pos_valid_o && pos_o == 6'(N - 1), "R6",
          {done_o, fail_o, pos_valid_o}, 3'b110);
    chk(root_cnt_o == 3'(cnt), "R8", root_cnt_o, cnt);
    @(negedge clk_i);
    chk(done_o && !pos_valid_o && root_cnt_o == 3'(cnt) && fail_o == !stopped, "R8",
        root_cnt_o, cnt);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", cur_tag, 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_tag = "reset";
    chk(!pos_valid_o && !err_loc_o && !inv_req_o && mag_eval_o == 0 && !done_o && !fail_o
        && root_cnt_o == 0 && pos_o == 0, "R9", {pos_valid_o, done_o, fail_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!pos_valid_o && !done_o && !fail_o && root_cnt_o == 0, "R9",
        {pos_valid_o, done_o, fail_o}, 0);

    // R7: degree 0, even with nonzero higher coefficients
    lam = '{1, 0, 0, 0, 0};
    om  = '{5, 0, 0, 0};
    run_case("deg0", 0, -1, 1'b0);
    lam = '{1, 'h33, 'h07, 0, 0};
    run_case("deg0_junk", 0, -1, 1'b0);

    // single root swept over every position
    for (int j0 = 0; j0 < N; j0++) begin
      build_loc(1, N - 1 - j0, 0, 0, 0);
      om = '{j0 + 1, 'h53, 0, 'h0E};
      run_case($sformatf("single_%0d", j0), 1, -1, 1'b0);
    end

    // adjacent root pairs over every neighbouring pair
    for (int j0 = 0; j0 < N - 1; j0++) begin
      build_loc(2, N - 1 - j0, N - 2 - j0, 0, 0);
      om = '{'hA5, j0 + 3, 'h21, 'h01};
      run_case($sformatf("pair_%0d", j0), 2, -1, 1'b0);
    end

    // four roots early in the data
    build_loc(4, N - 1 - 2, N - 1 - 5, N - 1 - 9, N - 1 - 13);
    om = '{'h11, 'h22, 'h44, 'h88};
    run_case("four_early", 4, -1, 1'b0);

    // two data roots, two parity roots, last at the final symbol
    build_loc(4, N - 1 - 3, N - 1 - 20, N - 1 - 33, N - 1 - 39);
    om = '{'h7F, 'h01, 'hC3, 'h5A};
    run_case("four_parity", 4, -1, 1'b0);

    // seam between the last data and first parity positions
    build_loc(2, N - 1 - 31, N - 1 - 32, 0, 0);
    om = '{'h9D, 'h02, 0, 'h40};
    run_case("seam", 2, -1, 1'b0);

    // one root outside the shortened block: failure at the end
    build_loc(4, N - 1 - 4, N - 1 - 17, N - 1 - 38, 100);
    om = '{'h3C, 'h0F, 'hF0, 'h81};
    run_case("outside", 4, -1, 1'b0);

    // declared degree above the true number of roots
    build_loc(2, N - 1 - 6, N - 1 - 35, 0, 0);
    run_case("overdeg", 3, -1, 1'b0);

    // arbitrary degree-4 locators, as left by more than T errors
    lam = '{1, 'h37, 'h5A, 'h11, 'h9C};
    om  = '{'h12, 'h34, 'h56, 'h78};
    run_case("many_a", 4, -1, 1'b0);
    lam = '{1, 'hE1, 'h04, 'hBB, 'h6D};
    run_case("many_b", 4, -1, 1'b0);

    // R10: restart in mid-search
    build_loc(4, N - 1 - 4, N - 1 - 17, N - 1 - 38, 100);
    om = '{'h3C, 'h0F, 'hF0, 'h81};
    run_case("abort", 4, 5, 1'b0);
    build_loc(4, N - 1 - 1, N - 1 - 8, N - 1 - 27, N - 1 - 36);
    om = '{'h66, 'h99, 'h0A, 'hD0};
    run_case("restart", 4, -1, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule